// File: doc/BRIEF.md
# Data cache line state controller

This block sequences every access to a small data cache. Each cache line is in one of three states: Invalid, Valid or Modified. For each processor access, the controller looks at the line the address maps to and picks the actions. It can answer from the cache, fill the line from memory, write a word to memory, update the cached copy, or move a dirty victim through a one-line push buffer. Each request carries its own copyback or write-through selection. A replaced dirty line is moved aside into the push buffer first. The new line is then fetched and the processor is answered. Only after that is the old line written back, so the processor never waits on the write-back.

A separate line-push command flushes a line to memory. Two bits of a control register shape the push. Bit 14 makes the push match the full address against the stored tag, so only a line that really holds that address is touched. When bit 14 is clear, the push acts on whatever line sits at the addressed index. Bit 20 turns the push into a pure discard: the line is dropped and its dirty data is lost. Memory is reached through a valid/ready port that moves one 32-bit word per beat. A whole line takes four beats, in ascending word order.

Addresses are byte addresses. Bits [3:2] select the word in a line, the next log2(lines) bits select the line, and the bits above form the tag.

Top module: `dcache_line_ctl`

## Requirements
- R1: After reset every line is Invalid, both request ports are ready, and no memory beat and no response is presented.
- R2: A read whose tag matches a Valid or Modified line returns the cached word in a single-cycle response pulse, with no memory beat and no change of line state.
- R3: A read miss fills the line with four read beats and leaves it Valid. If the victim was Modified, its four words go to the push buffer first, and the buffer is written back (four write beats to the victim's own address) only after the response pulse.
- R4: A copyback write hit updates only the cached word and leaves the line Modified, with no memory beat.
- R5: A copyback write miss fills the line with four read beats, merges the written word and leaves the line Modified. A Modified victim is written back from the push buffer after the fill.
- R6: A write-through write makes exactly one memory write beat to its address. On a hit it also updates the cached word and keeps the line state. On a miss it allocates nothing.
- R7: A push on a Modified line, with bit 20 clear, writes the four words to memory. The line then becomes Invalid if the push's invalidate input is 1, and Valid otherwise.
- R8: A push on a Valid line makes no memory beat. The line becomes Invalid if the invalidate input or bit 20 is 1, and stays Valid otherwise.
- R9: With control bit 20 set, a push on a Modified line makes no memory beat and leaves the line Invalid, so its dirty data is lost. The control register reads back as written.
- R10: With control bit 14 set, a push acts only on a non-Invalid line whose tag matches the push address. With bit 14 clear, it acts on the line at the address's index whatever its tag.
- R11: From acceptance until the last memory beat of the operation (write-back included), neither port is ready. A push is accepted only when no processor request is offered.
- R12: A memory beat completes only when valid and ready are both high. While it waits, address, direction and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request offered |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_thru | input | 1 | 1 = write-through, 0 = copyback |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse for a processor request |
| rsp_rdata | output | DW | Read data, valid with rsp_valid on reads |
| push_valid | input | 1 | Line-push command offered |
| push_ready | output | 1 | Push command taken this cycle |
| push_addr | input | ADDR_W | Address selecting the line to push |
| push_inv | input | 1 | Invalidate the line after the push |
| push_done | output | 1 | One-cycle completion pulse for a push |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control register write value (bit 14 address match, bit 20 discard) |
| ctrl_rdata | output | 32 | Control register value |
| mem_valid | output | 1 | Memory beat requested |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | ADDR_W | Beat byte address |
| mem_wdata | output | DW | Write beat data |
| mem_rdata | input | DW | Read data, valid in the cycle a read beat completes |

## Verification
A hit answers on the cycle after acceptance. A miss answers one cycle after its fourth read beat completes. A write-through answers one cycle after its single write beat. Write-back beats of the push buffer come after the response, so an operation is only complete once both ports are ready again. The bench therefore opens a window at acceptance and samples on falling edges. It counts read and write beats until it has seen the response or push pulse and the controller is idle again. It then compares the beat counts, the read data and the position of the response relative to the write-back beats with a model built from the requirements. At the end of the run it compares the whole memory image with the model's memory.

// File: rtl/dcl_pkg.sv
package dcl_pkg;

    typedef enum logic [1:0] {
        LN_INVALID  = 2'd0,
        LN_VALID    = 2'd1,
        LN_MODIFIED = 2'd2
    } line_st_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_FILL,
        F_WTWR,
        F_DONE,
        F_PUSHWB
    } fsm_e;

    typedef enum logic [1:0] {
        OP_READ,
        OP_WRITE,
        OP_PUSH
    } op_e;

    localparam int CTRL_W       = 32;
    localparam int CTRL_PA_BIT  = 14;
    localparam int CTRL_DROP_BIT = 20;

    // State a line takes after a push command
    function automatic line_st_e push_result(line_st_e cur, logic inv, logic drop);
        if (cur == LN_INVALID || inv || drop)
            return LN_INVALID;
        return LN_VALID;
    endfunction

    // State a line takes once its fill completes
    function automatic line_st_e fill_result(logic is_write);
        return is_write ? LN_MODIFIED : LN_VALID;
    endfunction

endpackage

// File: rtl/dcl_line_array.sv
module dcl_line_array
    import dcl_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int TAG_W  = 26,
    parameter int WORDS  = 4,
    parameter int DW     = 32,
    localparam int IDX_W  = $clog2(NLINES),
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [IDX_W-1:0]           rd_idx,
    output line_st_e                   rd_state,
    output logic [TAG_W-1:0]           rd_tag,
    output logic [WORDS-1:0][DW-1:0]   rd_line,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic                       st_we,
    input  line_st_e                   st_val,
    input  logic                       tag_we,
    input  logic [TAG_W-1:0]           tag_val,
    input  logic                       wd_we,
    input  logic [WSEL_W-1:0]          wd_sel,
    input  logic [DW-1:0]              wd_val
);
    line_st_e                 st_r  [NLINES];
    logic [TAG_W-1:0]         tag_r [NLINES];
    logic [WORDS-1:0][DW-1:0] dat_r [NLINES];
    logic [NLINES-1:0]        sel;

    genvar g;
    generate
        for (g = 0; g < NLINES; g++) begin : gen_sel
            assign sel[g] = (wr_idx == IDX_W'(g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NLINES; i++) begin
                st_r[i]  <= LN_INVALID;
                tag_r[i] <= '0;
                dat_r[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NLINES; i++) begin
                if (sel[i]) begin
                    if (st_we)  st_r[i]  <= st_val;
                    if (tag_we) tag_r[i] <= tag_val;
                    if (wd_we)  dat_r[i][wd_sel] <= wd_val;
                end
            end
        end
    end

    assign rd_state = st_r[rd_idx];
    assign rd_tag   = tag_r[rd_idx];
    assign rd_line  = dat_r[rd_idx];

endmodule

// File: rtl/dcl_push_buf.sv
module dcl_push_buf #(
    parameter int BASE_W = 28,
    parameter int WORDS  = 4,
    parameter int DW     = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic                     clear,
    input  logic [BASE_W-1:0]        load_base,
    input  logic [WORDS-1:0][DW-1:0] load_line,
    output logic                     full,
    output logic [BASE_W-1:0]        base,
    output logic [WORDS-1:0][DW-1:0] line
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            base <= '0;
            line <= '0;
        end else if (load) begin
            full <= 1'b1;
            base <= load_base;
            line <= load_line;
        end else if (clear) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/dcl_beat_ctr.sv
module dcl_beat_ctr #(
    parameter int WORDS = 4,
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [WSEL_W-1:0] beat,
    output logic              last
);
    // WORDS is a power of two, so the counter wraps to zero after the last beat
    always_ff @(posedge clk) begin
        if (rst)      beat <= '0;
        else if (adv) beat <= beat + 1'b1;
    end

    assign last = (beat == WSEL_W'(WORDS - 1));
endmodule

// File: rtl/dcache_line_ctl.sv
module dcache_line_ctl
    import dcl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DW     = 32,
    parameter int NLINES = 4,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_thru,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    input  logic              push_valid,
    output logic              push_ready,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              push_inv,
    output logic              push_done,
    input  logic              ctrl_we,
    input  logic [31:0]       ctrl_wdata,
    output logic [31:0]       ctrl_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata
);
    localparam int IDX_W  = $clog2(NLINES);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int OFF_W  = WSEL_W + 2;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int BASE_W = TAG_W + IDX_W;

    fsm_e               fsm, fsm_nxt;
    op_e                op_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DW-1:0]      wdata_q;
    logic               merge_q;
    logic [CTRL_W-1:0]  ctrl_q;

    logic [ADDR_W-1:0]  look_addr;
    logic [IDX_W-1:0]   cur_idx;
    logic [TAG_W-1:0]   cur_tag;
    logic [WSEL_W-1:0]  wsel_q;
    logic               idle, hit, match_pa, drop;

    line_st_e                 ln_state;
    logic [TAG_W-1:0]         ln_tag;
    logic [WORDS-1:0][DW-1:0] ln_line;

    logic               st_we, tag_we, wd_we;
    line_st_e           st_val;
    logic [WSEL_W-1:0]  wd_sel;
    logic [DW-1:0]      wd_val;

    logic               pb_load, pb_clear, pb_full;
    logic [BASE_W-1:0]  pb_base;
    logic [WORDS-1:0][DW-1:0] pb_line;

    logic               beat_adv, beat_last;
    logic [WSEL_W-1:0]  beat;

    logic               req_fire, push_fire;

    assign idle       = (fsm == F_IDLE);
    assign req_ready  = idle;
    assign push_ready = idle && !req_valid;
    assign req_fire   = req_valid && req_ready;
    assign push_fire  = push_valid && push_ready;

    assign look_addr = !idle     ? addr_q   :
                       req_valid ? req_addr : push_addr;
    assign cur_idx   = look_addr[OFF_W +: IDX_W];
    assign cur_tag   = look_addr[ADDR_W-1 -: TAG_W];
    assign wsel_q    = addr_q[2 +: WSEL_W];

    assign hit      = (ln_state != LN_INVALID) && (ln_tag == cur_tag);
    assign match_pa = ctrl_q[CTRL_PA_BIT] ? hit : 1'b1;
    assign drop     = ctrl_q[CTRL_DROP_BIT];
    assign ctrl_rdata = ctrl_q;

    dcl_line_array #(
        .NLINES(NLINES), .TAG_W(TAG_W), .WORDS(WORDS), .DW(DW)
    ) u_lines (
        .clk(clk), .rst(rst),
        .rd_idx(cur_idx), .rd_state(ln_state), .rd_tag(ln_tag), .rd_line(ln_line),
        .wr_idx(cur_idx), .st_we(st_we), .st_val(st_val),
        .tag_we(tag_we), .tag_val(cur_tag),
        .wd_we(wd_we), .wd_sel(wd_sel), .wd_val(wd_val)
    );

    dcl_push_buf #(
        .BASE_W(BASE_W), .WORDS(WORDS), .DW(DW)
    ) u_pbuf (
        .clk(clk), .rst(rst),
        .load(pb_load), .clear(pb_clear),
        .load_base({ln_tag, cur_idx}), .load_line(ln_line),
        .full(pb_full), .base(pb_base), .line(pb_line)
    );

    dcl_beat_ctr #(
        .WORDS(WORDS)
    ) u_beat (
        .clk(clk), .rst(rst), .adv(beat_adv), .beat(beat), .last(beat_last)
    );

    always_comb begin
        fsm_nxt   = fsm;
        st_we     = 1'b0;
        st_val    = LN_INVALID;
        tag_we    = 1'b0;
        wd_we     = 1'b0;
        wd_sel    = wsel_q;
        wd_val    = wdata_q;
        pb_load   = 1'b0;
        pb_clear  = 1'b0;
        beat_adv  = 1'b0;
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        rsp_valid = 1'b0;
        push_done = 1'b0;
        case (fsm)
            F_IDLE: begin
                if (req_valid) begin
                    if (req_write && req_thru) begin
                        if (hit) begin
                            wd_we  = 1'b1;
                            wd_sel = req_addr[2 +: WSEL_W];
                            wd_val = req_wdata;
                        end
                        fsm_nxt = F_WTWR;
                    end else if (hit) begin
                        if (req_write) begin
                            wd_we  = 1'b1;
                            wd_sel = req_addr[2 +: WSEL_W];
                            wd_val = req_wdata;
                            st_we  = 1'b1;
                            st_val = LN_MODIFIED;
                        end
                        fsm_nxt = F_DONE;
                    end else begin
                        pb_load = (ln_state == LN_MODIFIED);
                        fsm_nxt = F_FILL;
                    end
                end else if (push_valid) begin
                    if (match_pa && ln_state != LN_INVALID) begin
                        st_we   = 1'b1;
                        st_val  = push_result(ln_state, push_inv, drop);
                        pb_load = (ln_state == LN_MODIFIED) && !drop;
                    end
                    fsm_nxt = pb_load ? F_PUSHWB : F_DONE;
                end
            end
            F_FILL: begin
                mem_valid = 1'b1;
                mem_addr  = {cur_tag, cur_idx, beat, 2'b00};
                if (mem_ready) begin
                    wd_we    = 1'b1;
                    wd_sel   = beat;
                    wd_val   = mem_rdata;
                    beat_adv = 1'b1;
                    if (beat_last) begin
                        st_we   = 1'b1;
                        st_val  = fill_result(op_q == OP_WRITE);
                        tag_we  = 1'b1;
                        fsm_nxt = F_DONE;
                    end
                end
            end
            F_WTWR: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = addr_q;
                mem_wdata = wdata_q;
                if (mem_ready)
                    fsm_nxt = F_DONE;
            end
            F_DONE: begin
                wd_we = merge_q;
                if (op_q == OP_PUSH) begin
                    push_done = 1'b1;
                    fsm_nxt   = F_IDLE;
                end else begin
                    rsp_valid = 1'b1;
                    fsm_nxt   = pb_full ? F_PUSHWB : F_IDLE;
                end
            end
            F_PUSHWB: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {pb_base, beat, 2'b00};
                mem_wdata = pb_line[beat];
                if (mem_ready) begin
                    beat_adv = 1'b1;
                    if (beat_last) begin
                        pb_clear = 1'b1;
                        fsm_nxt  = (op_q == OP_PUSH) ? F_DONE : F_IDLE;
                    end
                end
            end
            default: fsm_nxt = F_IDLE;
        endcase
    end

    assign rsp_rdata = (rsp_valid && op_q == OP_READ) ? ln_line[wsel_q] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm     <= F_IDLE;
            op_q    <= OP_READ;
            addr_q  <= '0;
            wdata_q <= '0;
            merge_q <= 1'b0;
            ctrl_q  <= '0;
        end else begin
            fsm <= fsm_nxt;
            if (ctrl_we)
                ctrl_q <= ctrl_wdata;
            if (req_fire) begin
                op_q    <= req_write ? OP_WRITE : OP_READ;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                merge_q <= req_write && !req_thru && !hit;
            end else if (push_fire) begin
                op_q    <= OP_PUSH;
                addr_q  <= push_addr;
                merge_q <= 1'b0;
            end else if (fsm == F_DONE) begin
                merge_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dcl_checker.sv
module dcl_checker #(
    parameter int ADDR_W = 32,
    parameter int DW     = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              push_ready,
    input logic              rsp_valid,
    input logic              push_done,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DW-1:0]     mem_wdata
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (req_ready && !mem_valid && !rsp_valid && !push_done)); // R1

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R2

    AST_NO_FILL_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !(mem_valid && !mem_write)); // R3

    AST_PUSH_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        push_done |-> (!mem_valid && !rsp_valid)); // R7

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (!req_ready && !push_ready)); // R11

    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                       $stable(mem_write) && $stable(mem_wdata))); // R12
endmodule

bind dcache_line_ctl dcl_checker #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .push_ready(push_ready),
    .rsp_valid(rsp_valid), .push_done(push_done), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
);

// File: tb/tb_dcache_line_ctl.sv
module tb_dcache_line_ctl;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write, req_thru;
    logic [31:0] req_addr, req_wdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        push_valid, push_ready, push_inv, push_done;
    logic [31:0] push_addr;
    logic        ctrl_we;
    logic [31:0] ctrl_wdata, ctrl_rdata;
    logic        mem_valid, mem_ready, mem_write;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    always #4 clk = ~clk;

    dcache_line_ctl dut (.*);

    logic [31:0] mem [64];
    assign mem_rdata = mem[mem_addr[7:2]];

    int errors = 0, checks = 0;
    int rd_beats, wr_beats, wr_at_rsp;
    bit seen_rsp, seen_done, busy_bad;
    logic [31:0] got_data;

    // model state
    int          mst [4];
    int          mtg [4];
    logic [31:0] mdat [4][4];
    logic [31:0] emem [64];
    bit          m_pa, m_drop;
    int          er, ew;
    logic [31:0] edata;
    bit          need_order;
    string       rtag;

    always @(negedge clk) begin
        mem_ready = ($urandom_range(0, 3) != 0);
        if (!rst) begin
            if (mem_valid && mem_ready) begin
                if (mem_write) begin
                    mem[mem_addr[7:2]] = mem_wdata;
                    wr_beats++;
                end else begin
                    rd_beats++;
                end
            end
            if (rsp_valid) begin
                seen_rsp  = 1'b1;
                got_data  = rsp_rdata;
                wr_at_rsp = wr_beats;
            end
            if (push_done) seen_done = 1'b1;
            if (mem_valid && (req_ready || push_ready)) busy_bad = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic victim_out(input int idx);
        for (int k = 0; k < 4; k++)
            emem[(mtg[idx] << 4) | (idx << 2) | k] = mdat[idx][k];
        ew += 4;
    endtask

    task automatic line_in(input int idx, input int tg);
        for (int k = 0; k < 4; k++)
            mdat[idx][k] = emem[(tg << 4) | (idx << 2) | k];
        mtg[idx] = tg;
        er += 4;
    endtask

    // kind: 0 read, 1 write, 2 push
    task automatic model(input int kind, input bit thru, input int a,
                         input logic [31:0] d, input bit inv);
        int idx, tg, w;
        bit hit;
        idx = (a >> 4) & 3;  tg = a >> 6;  w = (a >> 2) & 3;
        hit = (mst[idx] != 0) && (mtg[idx] == tg);
        er = 0; ew = 0; edata = '0; need_order = 0;
        if (kind == 0) begin
            if (hit) begin
                rtag = "R2";
            end else begin
                rtag = "R3";
                if (mst[idx] == 2) begin victim_out(idx); need_order = 1; end
                line_in(idx, tg);
                mst[idx] = 1;
            end
            edata = mdat[idx][w];
        end else if (kind == 1 && thru) begin
            rtag = "R6";
            ew = 1;
            emem[a >> 2] = d;
            if (hit) mdat[idx][w] = d;
        end else if (kind == 1) begin
            if (hit) begin
                rtag = "R4";
            end else begin
                rtag = "R5";
                if (mst[idx] == 2) victim_out(idx);
                line_in(idx, tg);
            end
            mdat[idx][w] = d;
            mst[idx] = 2;
        end else begin
            if ((m_pa ? hit : 1'b1) && mst[idx] != 0) begin
                if (mst[idx] == 2 && m_drop)      rtag = "R9";
                else if (mst[idx] == 2)            rtag = "R7";
                else                               rtag = "R8";
                if (mst[idx] == 2 && !m_drop) victim_out(idx);
                mst[idx] = (inv || m_drop) ? 0 : 1;
            end else begin
                rtag = "R10";
            end
        end
    endtask

    task automatic do_op(input int kind, input bit thru, input int a,
                         input logic [31:0] d, input bit inv);
        int n;
        model(kind, thru, a, d, inv);
        @(negedge clk);
        rd_beats = 0; wr_beats = 0; wr_at_rsp = 0;
        seen_rsp = 0; seen_done = 0; busy_bad = 0;
        if (kind == 2) begin
            push_valid = 1'b1; push_addr = a; push_inv = inv;
        end else begin
            req_valid = 1'b1; req_write = (kind == 1); req_thru = thru;
            req_addr = a; req_wdata = d;
        end
        @(negedge clk);
        req_valid = 1'b0; push_valid = 1'b0;
        n = 0;
        #1;
        while (!((seen_rsp || seen_done) && req_ready) && n < 2000) begin
            @(negedge clk); #1;
            n++;
        end
        chk(n < 2000, rtag, "operation completes", n, 0);
        if (kind == 2) chk(seen_done && !seen_rsp, rtag, "push done pulse", seen_done, 1);
        else           chk(seen_rsp && !seen_done, rtag, "response pulse", seen_rsp, 1);
        chk(rd_beats == er, rtag, "read beats", rd_beats, er);
        chk(wr_beats == ew, rtag, "write beats", wr_beats, ew);
        if (kind == 0) chk(got_data == edata, rtag, "read data", got_data, edata);
        if (need_order) chk(wr_at_rsp == 0, "R3", "write-back after response", wr_at_rsp, 0);
        chk(!busy_bad, "R11", "ports blocked during beats", busy_bad, 0);
    endtask

    task automatic set_ctrl(input bit pa, input bit drop_bit);
        logic [31:0] v;
        v = ($urandom() & ~32'h0010_4000) | (32'(pa) << 14) | (32'(drop_bit) << 20);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
        m_pa = pa; m_drop = drop_bit;
        chk(ctrl_rdata == v, "R9", "control readback", ctrl_rdata, v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R11 watchdog: actual=hung expected=idle");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        req_valid = 0; req_write = 0; req_thru = 0; req_addr = 0; req_wdata = 0;
        push_valid = 0; push_addr = 0; push_inv = 0;
        ctrl_we = 0; ctrl_wdata = 0; mem_ready = 0;
        m_pa = 0; m_drop = 0;
        for (int i = 0; i < 64; i++) begin
            mem[i]  = 32'h1000_0000 + i * 32'h111;
            emem[i] = mem[i];
        end
        for (int i = 0; i < 4; i++) begin
            mst[i] = 0; mtg[i] = 0;
            for (int k = 0; k < 4; k++) mdat[i][k] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R1 reset state
        chk(req_ready && push_ready, "R1", "ports ready after reset", {req_ready, push_ready}, 2'b11);
        chk(!mem_valid && !rsp_valid, "R1", "no beat after reset", mem_valid, 0);

        // directed corners
        do_op(0, 0, 32'h04, 0, 0);                // R1/R3 clean read miss
        do_op(1, 0, 32'h00, 32'hA5A5_0001, 0);    // R4 write hit
        do_op(0, 0, 32'h00, 0, 0);                // R2 read hit
        do_op(0, 0, 32'h48, 0, 0);                // R3 miss, dirty victim
        do_op(1, 1, 32'h44, 32'hBEEF_0002, 0);    // R6 write-through hit
        do_op(0, 0, 32'h44, 0, 0);                // R6 hit data updated
        do_op(1, 1, 32'h84, 32'hCAFE_0003, 0);    // R6 write-through miss
        do_op(0, 0, 32'h84, 0, 0);                // R6 no allocate: miss
        do_op(1, 0, 32'h18, 32'h1111_0004, 0);    // R5 write miss
        do_op(1, 0, 32'h58, 32'h2222_0005, 0);    // R5 dirty victim
        do_op(2, 0, 32'h50, 0, 0);                // R7 push keep
        do_op(0, 0, 32'h58, 0, 0);                // R7 line stayed Valid
        do_op(2, 0, 32'h50, 0, 0);                // R8 push Valid, keep
        do_op(2, 0, 32'h50, 0, 1);                // R8 push Valid, invalidate
        do_op(0, 0, 32'h58, 0, 0);                // miss again
        set_ctrl(0, 1);
        do_op(1, 0, 32'h24, 32'h3333_0006, 0);
        do_op(2, 0, 32'h20, 0, 0);                // R9 drop dirty
        do_op(0, 0, 32'h24, 0, 0);                // R9 old memory value
        set_ctrl(1, 0);
        do_op(1, 0, 32'h30, 32'h4444_0007, 0);
        do_op(2, 0, 32'hF0, 0, 1);                // R10 tag mismatch: nothing
        do_op(0, 0, 32'h30, 0, 0);                // R10 still hit
        do_op(2, 0, 32'h30, 0, 1);                // R10 match: pushed
        set_ctrl(0, 0);
        do_op(1, 0, 32'h34, 32'h5555_0008, 0);
        do_op(2, 0, 32'hF0, 0, 0);                // R10 index only

        // constrained random
        for (int t = 0; t < 400; t++) begin
            int sel;
            sel = $urandom_range(0, 7);
            if (sel == 7)
                set_ctrl($urandom_range(0, 1), ($urandom_range(0, 3) == 0));
            else if (sel <= 2)
                do_op(0, 0, $urandom_range(0, 63) * 4, 0, 0);
            else if (sel <= 4)
                do_op(1, 0, $urandom_range(0, 63) * 4, $urandom(), 0);
            else if (sel == 5)
                do_op(1, 1, $urandom_range(0, 63) * 4, $urandom(), 0);
            else
                do_op(2, 0, $urandom_range(0, 63) * 4, 0, $urandom_range(0, 1));
        end

        // memory image against the model (R7 R9)
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < 64; i++)
                if (mem[i] !== emem[i]) begin
                    bad++;
                    $display("FAIL R7 memory word %0d: actual=%0h expected=%0h", i, mem[i], emem[i]);
                end
            checks++;
            if (bad != 0) errors++;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule